// File: doc/BRIEF.md
# Synchronous Transport Frame Alignment Detector

This block locates and tracks frame boundaries in a received, byte-aligned stream built from frames of 9 rows by 270 columns (2,430 bytes). The stream carries one byte per cycle in which the valid strobe is high. Every frame opens with a six-byte framing marker: three 0xF6 bytes followed by three 0x28 bytes. These bytes are sent unscrambled, so the detector sits ahead of any descrambler. Recovering byte boundaries from a serial line is the job of an earlier stage.

The detector moves through three phases. In the search phase it tests every byte position against the marker. A first hit moves it to a confirmation phase. In that phase it expects the marker to end again exactly one frame later, and a hit there locks it. While locked it tests the marker only at the expected position and ignores lookalikes elsewhere. It drops back to search only after a run of consecutive bad markers. While locked it labels each accepted byte with its 1-based row and column, and it pulses a start-of-frame flag for the byte at row 1, column 1. These labels let downstream overhead extractors and payload handlers work without framing logic of their own.

Top module: `stm_frame_sync`

## Requirements
- R1: After reset `outOfFrame` is 1, `inFrame` is 0, `sofPulse` is 0, and `rowIdx` and `colIdx` are 0.
- R2: In the search phase, six consecutive accepted bytes F6,F6,F6,28,28,28 at any alignment move the block to the confirmation phase. The move happens at the clock edge that accepts the last of the six bytes. In that phase `outOfFrame` and `inFrame` are both 0.
- R3: In the confirmation phase, if the marker ends again on the accepted byte exactly 2,430 accepted bytes after the first hit, `inFrame` rises at that edge. The search phase never moves straight to `inFrame`.
- R4: In the confirmation phase, a bad marker at the expected position returns the block to the search phase, and `outOfFrame` goes back to 1.
- R5: While locked, up to three consecutive frames with a bad marker keep `inFrame` at 1. A good marker clears the run of misses.
- R6: While locked, the fourth consecutive bad marker clears `inFrame` and sets `outOfFrame` at the edge that accepts the sixth marker position.
- R7: While locked, `sofPulse` is high for exactly one cycle, the cycle after the edge that accepts the byte at row 1, column 1. That is one pulse per frame.
- R8: On each accepted byte, `rowIdx` (1..9) and `colIdx` (1..270) are registered with that byte's position if the block is locked when the byte arrives. Otherwise both are registered as 0.
- R9: A cycle with `byteValid` at 0 accepts nothing. Its data is ignored, the position labels and status hold, and `sofPulse` is 0.
- R10: While locked, a marker pattern at any position other than the frame start neither realigns the frame nor changes the status.
- R11: In the search phase, a partial marker (five of the six bytes correct) does not leave the search phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteIn | input | 8 | Received byte |
| byteValid | input | 1 | High when `byteIn` carries a byte |
| inFrame | output | 1 | Locked to the frame boundary |
| outOfFrame | output | 1 | Searching for the marker |
| sofPulse | output | 1 | One-cycle flag for the byte at row 1, column 1 |
| rowIdx | output | 4 | Row of the last accepted byte (1..9), 0 when not locked |
| colIdx | output | 9 | Column of the last accepted byte (1..270), 0 when not locked |

## Verification
The stream opens with random filler. The filler contains a five-of-six partial marker, which separates a full-window compare from a prefix match. It is followed by a frame start at an odd offset, which shows the search works at any alignment. Valid strobes are gapped at random throughout, and idle cycles carry junk data, so any counting of idle cycles or latching of unqualified data shows up. Locked frames include a fake marker in mid-frame, which exposes realignment. Runs of three and four corrupted markers around a good one bracket the miss threshold and show whether the miss count clears. A corrupted frame right after a first hit separates a confirmed lock from a single-hit lock.

// File: rtl/stm_sync_pkg.sv
package stm_sync_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } syncState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadPos;  // realign position counter to just past the marker
    logic locked;   // label accepted bytes with row/column
  } ctrlStrobes_t;

  // datapath -> control flags
  typedef struct packed {
    logic accept;     // a byte is taken this cycle
    logic markerHit;  // window (history plus current byte) equals marker
    logic atCheck;    // current byte sits at the expected marker end
  } dpFlags_t;

endpackage

// File: rtl/stm_sync_datapath.sv
module stm_sync_datapath
  import stm_sync_pkg::*;
#(
  parameter int ROWS       = 9,
  parameter int COLS       = 270,
  parameter int RUN_LEN    = 3,
  parameter logic [7:0] LEAD_BYTE  = 8'hF6,
  parameter logic [7:0] TRAIL_BYTE = 8'h28,
  parameter int ROW_OUT_W  = $clog2(ROWS + 1),
  parameter int COL_OUT_W  = $clog2(COLS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           byteIn,
  input  logic                 byteValid,
  input  ctrlStrobes_t         ctl,
  output dpFlags_t             flags,
  output logic [ROW_OUT_W-1:0] rowIdx,
  output logic [COL_OUT_W-1:0] colIdx,
  output logic                 sofPulse
);

  localparam int MARK_LEN = 2 * RUN_LEN;
  localparam int HIST_LEN = MARK_LEN - 1;
  localparam int ROW_W    = $clog2(ROWS);
  localparam int COL_W    = $clog2(COLS);

  logic [HIST_LEN-1:0][7:0] hist;     // hist[0] newest
  logic [MARK_LEN-1:0][7:0] window;   // window[0] = current byte
  logic [MARK_LEN-1:0]      byteOk;
  logic [ROW_W-1:0]         rowCnt;   // position of the next byte
  logic [COL_W-1:0]         colCnt;

  assign window[0] = byteIn;

  genvar k;
  generate
    for (k = 1; k < MARK_LEN; k++) begin : g_win
      assign window[k] = hist[k-1];
    end
    for (k = 0; k < MARK_LEN; k++) begin : g_cmp
      // window[MARK_LEN-1] is the first byte of the marker
      localparam logic [7:0] EXP = (MARK_LEN - 1 - k < RUN_LEN) ? LEAD_BYTE : TRAIL_BYTE;
      assign byteOk[k] = (window[k] == EXP);
    end
  endgenerate

  assign flags.accept    = byteValid;
  assign flags.markerHit = &byteOk;
  assign flags.atCheck   = (rowCnt == '0) && (colCnt == COL_W'(MARK_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist <= '0;
    end else if (byteValid) begin
      hist[0] <= byteIn;
      for (int i = 1; i < HIST_LEN; i++) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowCnt <= '0;
      colCnt <= '0;
    end else if (byteValid) begin
      if (ctl.loadPos) begin
        rowCnt <= '0;
        colCnt <= COL_W'(MARK_LEN);
      end else if (colCnt == COL_W'(COLS - 1)) begin
        colCnt <= '0;
        rowCnt <= (rowCnt == ROW_W'(ROWS - 1)) ? '0 : rowCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowIdx   <= '0;
      colIdx   <= '0;
      sofPulse <= 1'b0;
    end else if (byteValid) begin
      if (ctl.locked) begin
        rowIdx   <= ROW_OUT_W'(rowCnt) + 1'b1;
        colIdx   <= COL_OUT_W'(colCnt) + 1'b1;
        sofPulse <= (rowCnt == '0) && (colCnt == '0);
      end else begin
        rowIdx   <= '0;
        colIdx   <= '0;
        sofPulse <= 1'b0;
      end
    end else begin
      sofPulse <= 1'b0;
    end
  end

endmodule

// File: rtl/stm_sync_control.sv
module stm_sync_control
  import stm_sync_pkg::*;
#(
  parameter int MISS_LIMIT = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpFlags_t     flags,
  output ctrlStrobes_t ctl,
  output logic         inFrame,
  output logic         outOfFrame
);

  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  syncState_t        state;
  logic [MISS_W-1:0] missCnt;

  assign ctl.loadPos = (state == ST_SEARCH) && flags.accept && flags.markerHit;
  assign ctl.locked  = (state == ST_LOCKED);
  assign inFrame     = (state == ST_LOCKED);
  assign outOfFrame  = (state == ST_SEARCH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_SEARCH;
      missCnt <= '0;
    end else if (flags.accept) begin
      unique case (state)
        ST_SEARCH: begin
          if (flags.markerHit) state <= ST_CONFIRM;
        end
        ST_CONFIRM: begin
          if (flags.atCheck) begin
            state   <= flags.markerHit ? ST_LOCKED : ST_SEARCH;
            missCnt <= '0;
          end
        end
        ST_LOCKED: begin
          if (flags.atCheck) begin
            if (flags.markerHit) begin
              missCnt <= '0;
            end else if (missCnt == MISS_W'(MISS_LIMIT - 1)) begin
              state   <= ST_SEARCH;
              missCnt <= '0;
            end else begin
              missCnt <= missCnt + 1'b1;
            end
          end
        end
        default: state <= ST_SEARCH;
      endcase
    end
  end

endmodule

// File: rtl/stm_frame_sync.sv
module stm_frame_sync
  import stm_sync_pkg::*;
#(
  parameter int ROWS       = 9,
  parameter int COLS       = 270,
  parameter int RUN_LEN    = 3,
  parameter int MISS_LIMIT = 4,
  parameter logic [7:0] LEAD_BYTE  = 8'hF6,
  parameter logic [7:0] TRAIL_BYTE = 8'h28,
  parameter int ROW_OUT_W  = $clog2(ROWS + 1),
  parameter int COL_OUT_W  = $clog2(COLS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           byteIn,
  input  logic                 byteValid,
  output logic                 inFrame,
  output logic                 outOfFrame,
  output logic                 sofPulse,
  output logic [ROW_OUT_W-1:0] rowIdx,
  output logic [COL_OUT_W-1:0] colIdx
);

  ctrlStrobes_t ctl;
  dpFlags_t     flags;

  stm_sync_datapath #(
    .ROWS(ROWS), .COLS(COLS), .RUN_LEN(RUN_LEN),
    .LEAD_BYTE(LEAD_BYTE), .TRAIL_BYTE(TRAIL_BYTE),
    .ROW_OUT_W(ROW_OUT_W), .COL_OUT_W(COL_OUT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .byteValid(byteValid),
    .ctl(ctl), .flags(flags), .rowIdx(rowIdx), .colIdx(colIdx),
    .sofPulse(sofPulse)
  );

  stm_sync_control #(
    .MISS_LIMIT(MISS_LIMIT)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .flags(flags), .ctl(ctl),
    .inFrame(inFrame), .outOfFrame(outOfFrame)
  );

endmodule

// File: rtl/stm_sync_checker.sv
module stm_sync_checker #(
  parameter int ROWS      = 9,
  parameter int COLS      = 270,
  parameter int ROW_OUT_W = 4,
  parameter int COL_OUT_W = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 byteValid,
  input logic                 inFrame,
  input logic                 outOfFrame,
  input logic                 sofPulse,
  input logic [ROW_OUT_W-1:0] rowIdx,
  input logic [COL_OUT_W-1:0] colIdx
);

  a_r2_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(inFrame && outOfFrame));

  a_r3_no_direct_lock: assert property (@(posedge clk) disable iff (!rstN)
    $past(outOfFrame) |-> !inFrame);

  a_r6_drop_to_search: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inFrame) |-> outOfFrame);

  a_r7_sof_position: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |-> (inFrame && rowIdx == ROW_OUT_W'(1) && colIdx == COL_OUT_W'(1)));

  a_r8_zero_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    ($past(byteValid) && !$past(inFrame)) |-> (rowIdx == '0 && colIdx == '0));

  a_r8_label_range: assert property (@(posedge clk) disable iff (!rstN)
    (rowIdx <= ROW_OUT_W'(ROWS)) && (colIdx <= COL_OUT_W'(COLS)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(byteValid) |-> ($stable(rowIdx) && $stable(colIdx) && !sofPulse &&
                           $stable(inFrame) && $stable(outOfFrame)));

endmodule

bind stm_frame_sync stm_sync_checker #(
  .ROWS(ROWS), .COLS(COLS), .ROW_OUT_W(ROW_OUT_W), .COL_OUT_W(COL_OUT_W)
) i_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .inFrame(inFrame),
  .outOfFrame(outOfFrame), .sofPulse(sofPulse), .rowIdx(rowIdx), .colIdx(colIdx)
);

// File: tb/test_stm_frame_sync.sv
module test_stm_frame_sync;

  localparam int FRAME = 2430;
  localparam int NCOL  = 270;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic       byteValid = 1'b0;
  logic       inFrame, outOfFrame, sofPulse;
  logic [3:0] rowIdx;
  logic [8:0] colIdx;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  int sofSeen = 0;

  // behavioural reference
  int   mState = 0;   // 0 search, 1 confirm, 2 locked
  int   mPos = 0;
  int   mMiss = 0;
  byte unsigned mWin[$];
  int   eRow = 0, eCol = 0;
  bit   eSof = 0;

  always #2 clk = ~clk;

  stm_frame_sync i_stm_frame_sync (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .byteValid(byteValid),
    .inFrame(inFrame), .outOfFrame(outOfFrame), .sofPulse(sofPulse),
    .rowIdx(rowIdx), .colIdx(colIdx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit winMatch();
    if (mWin.size() != 6) return 0;
    for (int i = 0; i < 6; i++)
      if (mWin[i] != ((i < 3) ? 8'hF6 : 8'h28)) return 0;
    return 1;
  endfunction

  function automatic void modelStep(input bit v, input byte unsigned b);
    bit hit, chk;
    if (!v) begin eSof = 0; return; end
    mWin.push_back(b);
    if (mWin.size() > 6) void'(mWin.pop_front());
    hit = winMatch();
    if (mState == 2) begin
      eRow = mPos / NCOL + 1; eCol = mPos % NCOL + 1; eSof = (mPos == 0);
    end else begin
      eRow = 0; eCol = 0; eSof = 0;
    end
    if (mState == 0) begin
      if (hit) begin mState = 1; mPos = 6; end
    end else begin
      chk = (mPos == 5);
      mPos = (mPos + 1) % FRAME;
      if (chk) begin
        if (mState == 1) begin
          mState = hit ? 2 : 0; mMiss = 0;
        end else if (hit) mMiss = 0;
        else if (mMiss == 3) begin mState = 0; mMiss = 0; end
        else mMiss++;
      end
    end
  endfunction

  // drive at negedge, compare at next negedge
  task automatic step(input bit v, input byte unsigned b);
    byteValid = v; byteIn = b;
    if (rstN) modelStep(v, b);
    @(negedge clk);
    check(inFrame == (mState == 2), curReq, "inFrame", inFrame, mState == 2);
    check(outOfFrame == (mState == 0), curReq, "outOfFrame", outOfFrame, mState == 0);
    check(sofPulse == eSof, curReq, "sofPulse", sofPulse, eSof);
    check(rowIdx == eRow, curReq, "rowIdx", rowIdx, eRow);
    check(colIdx == eCol, curReq, "colIdx", colIdx, eCol);
    if (sofPulse) sofSeen++;
  endtask

  function automatic byte unsigned filler();
    byte unsigned x = 8'($urandom);
    if (x == 8'hF6 || x == 8'h28) x = 8'h11;
    return x;
  endfunction

  task automatic sendByte(input byte unsigned b);
    while ($urandom_range(0, 4) == 0) step(0, 8'($urandom));
    step(1, b);
  endtask

  task automatic sendFrame(input bit corrupt, input int fakeAt);
    for (int i = 0; i < FRAME; i++) begin
      byte unsigned b;
      if (i < 6) b = (i < 3) ? 8'hF6 : 8'h28;
      else if (fakeAt >= 0 && i >= fakeAt && i < fakeAt + 6)
        b = (i - fakeAt < 3) ? 8'hF6 : 8'h28;
      else b = filler();
      if (corrupt && i == 4) b = 8'h00;
      sendByte(b);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) step(0, 8'h00);
    rstN = 1'b1;
    step(0, 8'h00);
    check(outOfFrame && !inFrame && !sofPulse && rowIdx == 0 && colIdx == 0,
          "R1", "reset state", {outOfFrame, inFrame}, 2);

    curReq = "R11";
    repeat (50) sendByte(filler());
    sendByte(8'hF6); sendByte(8'hF6); sendByte(8'hF6);
    sendByte(8'h28); sendByte(8'h28); sendByte(8'h11);
    repeat (37) sendByte(filler());
    check(outOfFrame == 1, "R11", "partial marker outOfFrame", outOfFrame, 1);

    curReq = "R2";
    sendFrame(0, -1);
    check(!outOfFrame && !inFrame, "R2", "confirm phase status",
          {outOfFrame, inFrame}, 0);

    curReq = "R3";
    sendFrame(0, -1);
    check(inFrame == 1, "R3", "locked after second marker", inFrame, 1);

    curReq = "R7";
    sofSeen = 0;
    sendFrame(0, -1);
    check(sofSeen == 1, "R7", "sof pulses per frame", sofSeen, 1);

    curReq = "R8";
    sendByte(8'hF6);
    check(rowIdx == 1 && colIdx == 1, "R8", "first byte label col", colIdx, 1);
    for (int i = 1; i < FRAME; i++) sendByte((i < 6) ? ((i < 3) ? 8'hF6 : 8'h28) : filler());
    check(rowIdx == 9 && colIdx == 270, "R8", "last byte label col", colIdx, 270);

    curReq = "R9";
    begin
      int r0, c0;
      r0 = rowIdx; c0 = colIdx;
      repeat (20) step(0, 8'hF6);
      check(rowIdx == r0 && colIdx == c0 && !sofPulse, "R9", "idle hold col",
            colIdx, c0);
    end

    curReq = "R10";
    sendFrame(0, 1000);
    check(inFrame == 1, "R10", "fake marker ignored", inFrame, 1);

    curReq = "R5";
    repeat (3) sendFrame(1, -1);
    check(inFrame == 1, "R5", "three misses tolerated", inFrame, 1);
    sendFrame(0, -1);
    repeat (3) sendFrame(1, -1);
    check(inFrame == 1, "R5", "miss run cleared by good marker", inFrame, 1);

    curReq = "R6";
    sendFrame(1, -1);
    check(outOfFrame == 1 && inFrame == 0, "R6", "fourth miss drops", outOfFrame, 1);

    curReq = "R4";
    sendFrame(0, -1);
    check(!outOfFrame && !inFrame, "R4", "confirm entered", outOfFrame, 0);
    sendFrame(1, -1);
    check(outOfFrame == 1, "R4", "confirm failure returns to search", outOfFrame, 1);

    curReq = "R3";
    sendFrame(0, -1);
    sendFrame(0, -1);
    check(inFrame == 1, "R3", "relock", inFrame, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule